// File: doc/BRIEF.md
# One-Time-Programmable Array Direct-Access Controller

This block gives software register-level access to a partitioned, write-once storage array. Software loads a byte address and up to two write words, then writes a command code. The block checks the command against the partition the address falls in. It runs an accepted command for a fixed number of cycles against the internal array and then raises a done interrupt. A rejected command raises an error interrupt and changes nothing.

The array is split into five partitions, in byte order:

| Partition | Bytes | Role |
|---|---|---|
| 0 | 0x000–0x03F | software configuration A |
| 1 | 0x040–0x07F | software configuration B |
| 2 | 0x080–0x09F | hardware configuration |
| 3 | 0x0A0–0x0BF | secret |
| 4 | 0x0C0–0x0DF | life cycle |

Every partition except life cycle keeps its top 8 bytes as a digest slot. A digest command computes a placeholder fold of the partition's data words and stores it in that slot. A nonzero digest locks the partition against further writes.

A power-manager request starts initialisation. Commands are refused until the done response is high. The two software partitions can also be read through a read-only bus window, and a test window exposes the raw array. The array has its own power-on reset, so a block reset leaves its contents in place.

Top module: `otp_dai_ctrl`

## Requirements
- R1: Bus registers sit at these byte offsets: 0x00 interrupt state (bit0 done, bit1 error, write 1 to clear), 0x04 status, 0x08 address, 0x0C write word 0, 0x10 write word 1, 0x14 command, 0x18 read word 0, 0x1C read word 1. Command codes are 1 read, 2 write and 3 digest. An accepted command sets the done bit a fixed number of cycles later, and writing 1 to a bit clears it.
- R2: The partition of an address is the last one whose base is not above it. In partitions 0, 1, 2 and 4 an access moves two consecutive words, at the address and at the address plus 4. Addresses there must be 4-byte aligned.
- R3: In the secret partition an access moves one word. The address must be 8-byte aligned, write word 1 is not stored, and read word 1 returns 0.
- R4: A misaligned address, an address at or beyond 0xE0, a write that would reach the digest slot, or command code 0 is rejected. A rejection sets the error bit and leaves the array and the read words unchanged.
- R5: A write is rejected if any word it touches is already nonzero.
- R6: A digest command must address a digest slot (partition base + size − 8) of partitions 0–3. It stores the XOR of the partition's data words XOR 0x5A3C96E1 in the low word, and their 32-bit sum XOR 0xA5C3691E in the high word. After that, writes to the partition and a second digest are rejected. A digest command aimed at partition 4 is rejected.
- R7: Status is one-hot. It reads 0x01 while initialisation is incomplete or a command runs, 0x40 after a rejected command, and 0x02 after initialisation completes or a command completes.
- R8: The done response rises one cycle after the request is first seen and stays high until block reset. Commands issued before it rises are rejected.
- R9: A command issued while another runs is rejected with the error bit. The running command still completes.
- R10: Bus reads at 0x1000 + address return array words of partitions 0 and 1 and 0 elsewhere. Reads at 0x2000 + address return the raw array word for any address below 0xE0.
- R11: Array contents survive a block reset and are cleared only by the array's power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, asynchronous, active low |
| por_n | input | 1 | Array power-on clear, asynchronous, active low |
| pwr_init_req | input | 1 | Initialisation request from power manager |
| pwr_init_done | output | 1 | Initialisation complete response |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 14 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from bus_addr |
| irq_done | output | 1 | Done interrupt (interrupt state bit 0) |
| irq_error | output | 1 | Error interrupt (interrupt state bit 1) |

## Verification
The assertions assume that the power request stays high once raised until the next block reset, and that bus writes are single-cycle strobes with a stable address. The bench drives every bus write for exactly one clock from a falling edge and holds the request high after initialisation. The checks on the interrupt relations also assume that only one command is ever running. The bench produces overlap only through the dedicated busy test, which issues the second command while the first is still counting down.

// File: rtl/otp_dai_pkg.sv
package otp_dai_pkg;

   localparam int unsigned NUM_PART   = 5;
   localparam int unsigned PART_W     = $clog2(NUM_PART);
   localparam int unsigned DAI_AW     = 11;
   localparam int unsigned DIG_BYTES  = 8;
   localparam int unsigned SECRET_IDX = 3;
   localparam int unsigned LC_IDX     = 4;
   localparam int unsigned SW_LAST    = 1;

   function automatic int unsigned part_bytes(int unsigned idx);
      case (idx)
         0, 1:    return 64;
         default: return 32;
      endcase
   endfunction

   function automatic int unsigned part_base(int unsigned idx);
      int unsigned acc = 0;
      for (int unsigned k = 0; k < NUM_PART; k++)
         if (k < idx) acc += part_bytes(k);
      return acc;
   endfunction

   localparam int unsigned TOTAL_BYTES = part_base(NUM_PART);
   localparam int unsigned WORDS       = TOTAL_BYTES / 4;
   localparam int unsigned WIW         = $clog2(WORDS);
   localparam int unsigned WIN_BYTES   = 2048;

   localparam int unsigned REG_INTR   = 'h00;
   localparam int unsigned REG_STATUS = 'h04;
   localparam int unsigned REG_ADDR   = 'h08;
   localparam int unsigned REG_WD0    = 'h0C;
   localparam int unsigned REG_WD1    = 'h10;
   localparam int unsigned REG_CMD    = 'h14;
   localparam int unsigned REG_RD0    = 'h18;
   localparam int unsigned REG_RD1    = 'h1C;
   localparam int unsigned WIN_SW     = 'h1000;
   localparam int unsigned WIN_TEST   = 'h2000;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_READ   = 2'd1,
      CMD_WRITE  = 2'd2,
      CMD_DIGEST = 2'd3
   } dai_cmd_e;

   localparam logic [6:0] ST_PENDING  = 7'b0000001;
   localparam logic [6:0] ST_IDLE     = 7'b0000010;
   localparam logic [6:0] ST_PART_ERR = 7'b1000000;

endpackage

// File: rtl/otp_part_decode.sv
module otp_part_decode
   import otp_dai_pkg::*;
(
   input  logic [DAI_AW-1:0] addr_i,
   output logic [PART_W-1:0] part_o,
   output logic              secret_o,
   output logic              in_range_o,
   output logic              aligned_o,
   output logic              data_ok_o,
   output logic              dslot_o,
   output logic              has_dig_o,
   output logic [WIW-1:0]    word_o,
   output logic [WIW-1:0]    dig_word_o
);

   logic [31:0] a32, base, dend, dslot;

   always_comb begin
      a32    = {{(32-DAI_AW){1'b0}}, addr_i};
      part_o = '0;
      for (int unsigned i = 0; i < NUM_PART; i++)
         if (a32 >= part_base(i)) part_o = PART_W'(i);
      base       = part_base(int'(part_o));
      dslot      = base + part_bytes(int'(part_o)) - DIG_BYTES;
      has_dig_o  = (int'(part_o) != LC_IDX);
      secret_o   = (int'(part_o) == SECRET_IDX);
      in_range_o = (a32 < TOTAL_BYTES);
      aligned_o  = secret_o ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
      dend       = has_dig_o ? dslot : base + part_bytes(int'(part_o));
      data_ok_o  = (a32 + (secret_o ? 32'd4 : 32'd8)) <= dend;
      dslot_o    = has_dig_o && (a32 == dslot);
      word_o     = a32[WIW+1:2];
      dig_word_o = dslot[WIW+1:2];
   end

endmodule

// File: rtl/otp_fold.sv
module otp_fold
   import otp_dai_pkg::*;
#(
   parameter logic [31:0] SEED = 32'h5A3C_96E1
) (
   input  logic [31:0]       words_i [WORDS],
   input  logic [PART_W-1:0] part_i,
   output logic [63:0]       digest_o
);

   logic [31:0] x_acc, s_acc;
   int unsigned lo, hi;

   always_comb begin
      lo    = part_base(int'(part_i));
      hi    = lo + part_bytes(int'(part_i)) - DIG_BYTES;
      x_acc = SEED;
      s_acc = '0;
      for (int unsigned w = 0; w < WORDS; w++) begin
         if (w * 4 >= lo && w * 4 < hi) begin
            x_acc = x_acc ^ words_i[w];
            s_acc = s_acc + words_i[w];
         end
      end
      digest_o = {s_acc ^ ~SEED, x_acc};
   end

endmodule

// File: rtl/otp_store.sv
module otp_store
   import otp_dai_pkg::*;
(
   input  logic           clk,
   input  logic           por_n,
   input  logic           we0,
   input  logic [WIW-1:0] wa0,
   input  logic [31:0]    wd0,
   input  logic           we1,
   input  logic [WIW-1:0] wa1,
   input  logic [31:0]    wd1,
   output logic [31:0]    words_o [WORDS]
);

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                           words_o[i] <= '0;
         else if (we0 && wa0 == WIW'(i))       words_o[i] <= wd0;
         else if (we1 && wa1 == WIW'(i))       words_o[i] <= wd1;
      end
   end

endmodule

// File: rtl/otp_dai_ctrl.sv
module otp_dai_ctrl
   import otp_dai_pkg::*;
#(
   parameter int unsigned LATENCY  = 4,
   parameter int unsigned BUS_AW   = 14,
   parameter logic [31:0] DIG_SEED = 32'h5A3C_96E1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              pwr_init_req,
   output logic              pwr_init_done,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_done,
   output logic              irq_error
);

   localparam int unsigned CW = $clog2(LATENCY + 1);

   if (LATENCY < 2) begin : g_bad_lat
      $error("LATENCY must be at least 2");
   end
   if (TOTAL_BYTES > WIN_BYTES) begin : g_bad_size
      $error("array exceeds window span");
   end
   if (BUS_AW < 14) begin : g_bad_aw
      $error("bus address too narrow for windows");
   end

   logic [DAI_AW-1:0] addr_q;
   logic [31:0]       wd0_q, wd1_q, rd0_q, rd1_q;
   logic [1:0]        intr_q, intr_d;
   logic              init_q, busy_q, err_q;
   logic [CW-1:0]     cnt_q;
   dai_cmd_e          cmd_q;
   logic [WIW-1:0]    wi_q, dw_q;
   logic              sec_q;
   logic [PART_W-1:0] part_q;
   logic [6:0]        status_w;

   logic [31:0]       words [WORDS];
   logic [PART_W-1:0] d_part;
   logic              d_sec, d_rng, d_aln, d_dok, d_dslot, d_hasd;
   logic [WIW-1:0]    d_word, d_dword, d_next;
   logic [63:0]       digest;

   otp_part_decode u_dec (
      .addr_i(addr_q), .part_o(d_part), .secret_o(d_sec), .in_range_o(d_rng),
      .aligned_o(d_aln), .data_ok_o(d_dok), .dslot_o(d_dslot), .has_dig_o(d_hasd),
      .word_o(d_word), .dig_word_o(d_dword)
   );

   otp_fold #(.SEED(DIG_SEED)) u_fold (
      .words_i(words), .part_i(part_q), .digest_o(digest)
   );

   logic           exec, st_we0, st_we1;
   logic [WIW-1:0] st_wa0, st_wa1;
   logic [31:0]    st_wd0, st_wd1;

   assign exec   = busy_q && (cnt_q == CW'(1));
   assign st_we0 = exec && (cmd_q == CMD_WRITE || cmd_q == CMD_DIGEST);
   assign st_we1 = exec && ((cmd_q == CMD_WRITE && !sec_q) || cmd_q == CMD_DIGEST);
   assign st_wa0 = (cmd_q == CMD_DIGEST) ? dw_q : wi_q;
   assign st_wa1 = (cmd_q == CMD_DIGEST) ? dw_q + WIW'(1) : wi_q + WIW'(1);
   assign st_wd0 = (cmd_q == CMD_DIGEST) ? digest[31:0]  : wd0_q;
   assign st_wd1 = (cmd_q == CMD_DIGEST) ? digest[63:32] : wd1_q;

   otp_store u_store (
      .clk(clk), .por_n(por_n),
      .we0(st_we0), .wa0(st_wa0), .wd0(st_wd0),
      .we1(st_we1), .wa1(st_wa1), .wd1(st_wd1),
      .words_o(words)
   );

   // command legality check at issue time
   logic     reg_sp, cmd_wr, locked, zero_ok, legal;
   dai_cmd_e new_cmd;

   assign reg_sp  = (bus_addr < BUS_AW'(WIN_SW));
   assign cmd_wr  = bus_we && reg_sp && bus_addr == BUS_AW'(REG_CMD);
   assign new_cmd = dai_cmd_e'(bus_wdata[1:0]);
   assign d_next  = (d_word == WIW'(WORDS - 1)) ? d_word : d_word + WIW'(1);
   assign locked  = d_hasd && (words[d_dword] != '0 || words[d_dword + WIW'(1)] != '0);
   assign zero_ok = (words[d_word] == '0) && (d_sec || words[d_next] == '0);

   always_comb begin
      legal = init_q && !busy_q && d_rng && d_aln;
      case (new_cmd)
         CMD_READ:   legal = legal && (d_dok || d_dslot);
         CMD_WRITE:  legal = legal && d_dok && !locked && zero_ok;
         CMD_DIGEST: legal = legal && d_dslot && !locked;
         default:    legal = 1'b0;
      endcase
   end

   always_comb begin
      intr_d = intr_q;
      if (bus_we && reg_sp && bus_addr == BUS_AW'(REG_INTR))
         intr_d = intr_d & ~bus_wdata[1:0];
      if (exec)             intr_d[0] = 1'b1;
      if (cmd_wr && !legal) intr_d[1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0; wd0_q <= '0; wd1_q <= '0; rd0_q <= '0; rd1_q <= '0;
         intr_q <= '0; init_q <= 1'b0; busy_q <= 1'b0; err_q <= 1'b0;
         cnt_q  <= '0; cmd_q <= CMD_NONE; wi_q <= '0; dw_q <= '0;
         sec_q  <= 1'b0; part_q <= '0;
      end else begin
         intr_q <= intr_d;
         if (pwr_init_req && !init_q) begin
            init_q <= 1'b1;
            err_q  <= 1'b0;
         end
         if (bus_we && reg_sp) begin
            if (bus_addr == BUS_AW'(REG_ADDR)) addr_q <= bus_wdata[DAI_AW-1:0];
            if (bus_addr == BUS_AW'(REG_WD0))  wd0_q  <= bus_wdata;
            if (bus_addr == BUS_AW'(REG_WD1))  wd1_q  <= bus_wdata;
         end
         if (busy_q) cnt_q <= cnt_q - CW'(1);
         if (exec) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            if (cmd_q == CMD_READ) begin
               rd0_q <= words[wi_q];
               rd1_q <= sec_q ? '0 : words[wi_q + WIW'(1)];
            end
         end
         if (cmd_wr) begin
            if (legal) begin
               busy_q <= 1'b1;
               cnt_q  <= CW'(LATENCY);
               cmd_q  <= new_cmd;
               wi_q   <= d_word;
               dw_q   <= d_dword;
               sec_q  <= d_sec;
               part_q <= d_part;
            end else begin
               err_q  <= 1'b1;
            end
         end
      end
   end

   assign status_w = (!init_q || busy_q) ? ST_PENDING : (err_q ? ST_PART_ERR : ST_IDLE);

   logic [1:0]     win_sel;
   logic [10:0]    win_off;
   logic [WIW-1:0] win_word;

   assign win_sel  = bus_addr[12:11];
   assign win_off  = bus_addr[10:0];
   assign win_word = win_off[WIW+1:2];

   always_comb begin
      bus_rdata = '0;
      if (bus_addr[BUS_AW-1:13] != '0 && bus_addr[BUS_AW-1:11] == (BUS_AW-11)'(WIN_TEST >> 11)) begin
         if (32'(win_off) < TOTAL_BYTES) bus_rdata = words[win_word];
      end else if (bus_addr[BUS_AW-1:11] == (BUS_AW-11)'(WIN_SW >> 11)) begin
         if (32'(win_off) < part_base(SW_LAST + 1)) bus_rdata = words[win_word];
      end else if (win_sel == 2'b00 && bus_addr[BUS_AW-1:13] == '0) begin
         case (32'(win_off))
            REG_INTR:   bus_rdata = {30'b0, intr_q};
            REG_STATUS: bus_rdata = {25'b0, status_w};
            REG_ADDR:   bus_rdata = {{(32-DAI_AW){1'b0}}, addr_q};
            REG_WD0:    bus_rdata = wd0_q;
            REG_WD1:    bus_rdata = wd1_q;
            REG_RD0:    bus_rdata = rd0_q;
            REG_RD1:    bus_rdata = rd1_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign pwr_init_done = init_q;
   assign irq_done      = intr_q[0];
   assign irq_error     = intr_q[1];

endmodule

// File: rtl/otp_dai_chk.sv
module otp_dai_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_init_req,
   input logic       pwr_init_done,
   input logic       busy_q,
   input logic       irq_done,
   input logic [6:0] status_w,
   input logic       st_we0,
   input logic       st_we1
);

   // R7
   status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_w) == 1);

   // R8
   init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_init_done |=> pwr_init_done);

   // R8
   init_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_init_done) |-> $past(pwr_init_req));

   // R8
   busy_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> pwr_init_done);

   // R1
   done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_done) |-> $past(busy_q) && !busy_q);

   // R4
   store_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we0 || st_we1) |-> busy_q);

endmodule

bind otp_dai_ctrl otp_dai_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_init_req(pwr_init_req),
   .pwr_init_done(pwr_init_done), .busy_q(busy_q), .irq_done(irq_done),
   .status_w(status_w), .st_we0(st_we0), .st_we1(st_we1)
);

// File: tb/tb_otp_dai_ctrl.sv
module tb_otp_dai_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SEED = 32'h5A3C_96E1;

   logic        clk = 1'b0;
   logic        rst_n, por_n, pwr_init_req, bus_we;
   logic [13:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        pwr_init_done, irq_done, irq_error;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_dai_ctrl dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .pwr_init_req(pwr_init_req),
      .pwr_init_done(pwr_init_done), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done),
      .irq_error(irq_error)
   );

   typedef struct packed {
      logic [1:0]  op;
      logic [10:0] addr;
      logic [31:0] w0;
      logic [31:0] w1;
      logic        err;
      logic [31:0] r0;
      logic [31:0] r1;
   } vec_t;

   localparam logic [1:0] RD = 2'd1, WR = 2'd2, DG = 2'd3;
   localparam logic [31:0] HW_X = 32'h01020304 ^ 32'h05060708 ^ SEED;
   localparam logic [31:0] HW_S = (32'h01020304 + 32'h05060708) ^ ~SEED;
   localparam int NV = 22;

   localparam vec_t VEC [NV] = '{
      '{WR, 11'h000, 32'h11111111, 32'h22222222, 1'b0, 32'h0, 32'h0},       // R2
      '{RD, 11'h000, 32'h0, 32'h0, 1'b0, 32'h11111111, 32'h22222222},       // R2
      '{WR, 11'h044, 32'hAAAA0001, 32'hAAAA0002, 1'b0, 32'h0, 32'h0},       // R2
      '{RD, 11'h044, 32'h0, 32'h0, 1'b0, 32'hAAAA0001, 32'hAAAA0002},       // R2
      '{WR, 11'h002, 32'h1, 32'h1, 1'b1, 32'h0, 32'h0},                     // R4
      '{WR, 11'h000, 32'h5, 32'h6, 1'b1, 32'h0, 32'h0},                     // R5
      '{RD, 11'h000, 32'h0, 32'h0, 1'b0, 32'h11111111, 32'h22222222},       // R5
      '{WR, 11'h0A8, 32'hCAFE0001, 32'h0000DEAD, 1'b0, 32'h0, 32'h0},       // R3
      '{RD, 11'h0A8, 32'h0, 32'h0, 1'b0, 32'hCAFE0001, 32'h0},              // R3
      '{RD, 11'h0AC, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0},                     // R3
      '{WR, 11'h0A4, 32'h7, 32'h7, 1'b1, 32'h0, 32'h0},                     // R3
      '{WR, 11'h084, 32'h01020304, 32'h05060708, 1'b0, 32'h0, 32'h0},       // R2
      '{DG, 11'h098, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0},                     // R6
      '{RD, 11'h098, 32'h0, 32'h0, 1'b0, HW_X, HW_S},                       // R6
      '{WR, 11'h08C, 32'h9, 32'h9, 1'b1, 32'h0, 32'h0},                     // R6
      '{RD, 11'h08C, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0},                     // R6
      '{DG, 11'h098, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0},                     // R6
      '{DG, 11'h0D8, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0},                     // R6
      '{WR, 11'h0D8, 32'h0C0FFEE0, 32'h0C0FFEE1, 1'b0, 32'h0, 32'h0},       // R2
      '{RD, 11'h0D8, 32'h0, 32'h0, 1'b0, 32'h0C0FFEE0, 32'h0C0FFEE1},       // R2
      '{WR, 11'h034, 32'h3, 32'h3, 1'b1, 32'h0, 32'h0},                     // R4
      '{RD, 11'h100, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0}                      // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [13:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [10:0] a,
                         input logic [31:0] w0, input logic [31:0] w1,
                         output logic err, output logic [31:0] r0, output logic [31:0] r1);
      bus_wr(14'h08, {21'b0, a});
      bus_wr(14'h0C, w0);
      bus_wr(14'h10, w1);
      bus_wr(14'h14, {30'b0, op});
      err = irq_error;
      if (!err) begin
         for (int n = 0; n < 50 && !irq_done; n++) @(negedge clk);
      end
      bus_rd(14'h18, r0);
      bus_rd(14'h1C, r1);
      @(negedge clk);
      bus_wr(14'h00, 32'h3);
   endtask

   task automatic do_init;
      pwr_init_req = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic        e;
      logic [31:0] r0, r1, v;
      rst_n = 1'b0; por_n = 1'b0; pwr_init_req = 1'b0;
      bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; por_n = 1'b1;
      @(negedge clk);

      // reset state (R7, R8)
      bus_rd(14'h04, v); check("R7 status before init", v, 32'h01);
      bus_rd(14'h00, v); check("R1 interrupts after reset", v, 32'h0);
      check("R8 done low after reset", {31'b0, pwr_init_done}, 32'h0);

      // command before init refused (R8)
      do_cmd(RD, 11'h000, 0, 0, e, r0, r1);
      check("R8 command before init rejected", {31'b0, e}, 32'h1);

      do_init;
      check("R8 done after request", {31'b0, pwr_init_done}, 32'h1);
      bus_rd(14'h04, v); check("R7 status idle after init", v, 32'h02);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         do_cmd(VEC[i].op, VEC[i].addr, VEC[i].w0, VEC[i].w1, e, r0, r1);
         check($sformatf("R4 vector %0d error flag", i), {31'b0, e}, {31'b0, VEC[i].err});
         if (VEC[i].op == RD && !VEC[i].err) begin
            check($sformatf("R2 vector %0d read word 0", i), r0, VEC[i].r0);
            check($sformatf("R2 vector %0d read word 1", i), r1, VEC[i].r1);
         end
         bus_rd(14'h04, v);
         check($sformatf("R7 vector %0d status", i), v, VEC[i].err ? 32'h40 : 32'h02);
      end

      // busy overlap (R9)
      bus_wr(14'h08, 32'h000);
      bus_wr(14'h14, 32'h1);
      bus_rd(14'h04, v); check("R7 status while running", v, 32'h01);
      @(negedge clk);
      bus_wr(14'h14, 32'h1);
      check("R9 overlapping command rejected", {31'b0, irq_error}, 32'h1);
      for (int n = 0; n < 50 && !irq_done; n++) @(negedge clk);
      check("R9 running command completes", {31'b0, irq_done}, 32'h1);
      bus_rd(14'h18, v); check("R9 read data of running command", v, 32'h11111111);
      bus_wr(14'h00, 32'h1);
      bus_rd(14'h00, v); check("R1 write-one clears done only", v, 32'h2);
      bus_wr(14'h00, 32'h2);
      bus_rd(14'h00, v); check("R1 error cleared", v, 32'h0);

      // windows (R10)
      bus_rd(14'h1000, v); check("R10 sw window word 0", v, 32'h11111111);
      bus_rd(14'h1048, v); check("R10 sw window partition 1", v, 32'hAAAA0002);
      bus_rd(14'h1084, v); check("R10 sw window hides hw partition", v, 32'h0);
      bus_rd(14'h2084, v); check("R10 test window raw", v, 32'h01020304);
      bus_rd(14'h20A8, v); check("R10 test window secret", v, 32'hCAFE0001);

      // block reset keeps contents (R11)
      @(negedge clk);
      rst_n = 1'b0; pwr_init_req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 done cleared by block reset", {31'b0, pwr_init_done}, 32'h0);
      do_init;
      do_cmd(RD, 11'h044, 0, 0, e, r0, r1);
      check("R11 contents kept over block reset", r0, 32'hAAAA0001);

      // power-on clear (R11)
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      do_cmd(RD, 11'h044, 0, 0, e, r0, r1);
      check("R11 contents cleared by power-on", r0, 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule